// File: doc/BRIEF.md
# One-Bit Echo Delay Line with Mode-Controlled Muting

This block stores a one-bit delta-modulated audio stream in an on-chip bit memory and returns every sample after a fixed number of sample periods, giving the echo component for a karaoke-style mixer. The sample rate comes from the system clock divided by a fixed ratio. The delay therefore depends only on that ratio and on the memory depth. With the default values the delay is 8192 samples, which is about 131 ms at a 375 kHz clock. Raising the clock shortens the delay in the same proportion.

A two-bit mode code selects one of three behaviours. In running mode the echo is live. In muted mode samples keep flowing but the mute flag stays raised. In halted mode sampling stops and the mute flag is raised. The mute flag is meant to silence the whole downstream mix, both the dry and the delayed sound.

A running state is reached only after one complete pass over the memory. During that pass every location is loaded with an alternating idle pattern, so the first echo heard after unmuting is silence and not stale audio. The bits are packed into wide memory words. Each sample does a read-modify-write of one bit at a single wrapping address.

Top module: `echo_delay_line`

## Requirements
- R1: `strobe_o` pulses high for exactly one clock cycle every `CLK_DIV` (default 6) clock cycles whenever the block is not halted.
- R2: While running without interruption, the echo bit presented with strobe number j equals the input bit captured at strobe j-`DEPTH` (default 8192). The input is captured on the clock edge just before `strobe_o` goes high. `echo_o` changes only on that edge.
- R3: Mode code 2'b00 means run, 2'b01 and 2'b11 both mean mute, and 2'b10 means halt. In mute, strobes continue at the normal rate.
- R4: `mute_o` is high in every condition except the running state. It rises on the first clock edge after a non-run code is applied in the running state.
- R5: During and right after reset, `mute_o` is 1, `strobe_o` is 0 and `echo_o` is 0. Reset starts a fill pass at address 0.
- R6: A fill pass starts at address 0 and writes each location with bit 0 of its own address. After a fill pass that ends directly in the running state, the first `DEPTH` echo bits therefore equal bit 0 of the strobe index counted from the first running strobe (0, 1, 0, 1, ...).
- R7: If the run code is present while a fill pass is in progress, `mute_o` stays high until all `DEPTH` fill writes are done. Exactly `DEPTH`-1 strobes are seen with `mute_o` high, and `mute_o` is already low at the strobe of the last fill write.
- R8: Leaving the running state for mute or halt, and any exit from halt, restarts the fill pass from zero. A return to run therefore needs a full new pass.
- R9: In halt no strobe occurs. `echo_o` holds its value, and the address and memory contents are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | Delta-modulated input bit |
| mode_i | input | 2 | Mode code: 00 run, 01/11 mute, 10 halt |
| echo_o | output | 1 | Delayed bit |
| mute_o | output | 1 | High when the mixed output must be silenced |
| strobe_o | output | 1 | One-cycle pulse marking a new sample period |

## Verification
A corrupted address or a bad bit-lane merge in the packed words shows up as a wrong echo bit exactly one memory pass after the faulty write, so delayed data is compared strobe by strobe over more than a full pass. A fill counter that stops early or late moves the unmute strobe, and this is caught by counting the muted strobes in two separate fill passes. A halt that fails to freeze the divider or the storage shows as a strobe or an echo change within the first few cycles of the halt window. A skipped fill shows as a broken 0/1 pattern on the first strobe after unmuting.

// File: rtl/echo_dl_pkg.sv
package echo_dl_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_READY = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } ctl_state_e;

    localparam logic [1:0] MODE_RUN  = 2'b00;
    localparam logic [1:0] MODE_HALT = 2'b10;

    function automatic logic mode_is_run(input logic [1:0] m);
        return m == MODE_RUN;
    endfunction

    function automatic logic mode_is_halt(input logic [1:0] m);
        return m == MODE_HALT;
    endfunction

endpackage

// File: rtl/echo_tick_gen.sv
module echo_tick_gen #(
    parameter int CLK_DIV = 6
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_en_i,
    output logic tick_o,
    output logic strobe_o
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          strobe;
    } div_t;

    div_t q, d;

    always_comb begin
        d      = q;
        tick_o = run_en_i && (q.cnt == LAST);
        d.strobe = tick_o;
        if (run_en_i) begin
            d.cnt = tick_o ? '0 : q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    assign strobe_o = q.strobe;

    // R1: the divider count never runs past the last phase
    a_r1_count_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        q.cnt <= LAST);

    // R9: with sampling disabled the phase is held
    a_r9_phase_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_en_i |=> $stable(q.cnt));

endmodule

// File: rtl/echo_mode_ctl.sv
module echo_mode_ctl
    import echo_dl_pkg::*;
#(
    parameter int DEPTH = 8192
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] mode_i,
    input  logic       tick_i,
    output logic       run_en_o,
    output logic       restart_o,
    output logic       pattern_o,
    output logic       mute_o
);
    localparam int CW = $clog2(DEPTH);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    typedef struct packed {
        ctl_state_e    state;
        logic [CW-1:0] fill_cnt;
    } ctl_t;

    ctl_t q, d;
    logic want_run, want_halt;

    always_comb begin
        d         = q;
        restart_o = 1'b0;
        want_run  = mode_is_run(mode_i);
        want_halt = mode_is_halt(mode_i);
        case (q.state)
            ST_HALT: begin
                if (!want_halt) begin
                    d.state    = ST_FILL;
                    d.fill_cnt = '0;
                    restart_o  = 1'b1;
                end
            end
            ST_RUN: begin
                if (want_halt) begin
                    d.state = ST_HALT;
                end else if (!want_run) begin
                    d.state    = ST_FILL;
                    d.fill_cnt = '0;
                    restart_o  = 1'b1;
                end
            end
            ST_FILL: begin
                if (want_halt) begin
                    d.state = ST_HALT;
                end else if (tick_i) begin
                    if (q.fill_cnt == LAST) begin
                        d.state    = want_run ? ST_RUN : ST_READY;
                        d.fill_cnt = '0;
                    end else begin
                        d.fill_cnt = q.fill_cnt + CW'(1);
                    end
                end
            end
            default: begin
                if (want_halt) begin
                    d.state = ST_HALT;
                end else if (tick_i && want_run) begin
                    d.state = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.state    <= ST_FILL;
            q.fill_cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_en_o  = (q.state != ST_HALT);
    assign mute_o    = (q.state != ST_RUN);
    assign pattern_o = (q.state != ST_RUN);

    // R7: entering the running state requires a completed fill pass
    a_r7_unmute_after_full_pass: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.state == ST_RUN && $past(q.state) != ST_RUN) |->
            ($past(q.state) == ST_READY ||
             ($past(q.state) == ST_FILL && $past(q.fill_cnt) == LAST)));

    // R4: a halt request mutes by the next cycle
    a_r4_halt_mutes: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_is_halt(mode_i) |=> mute_o);

    // R8: leaving run for a non-run code restarts the fill count
    a_r8_refill_from_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.state == ST_RUN && !mode_is_run(mode_i) && !mode_is_halt(mode_i)) |=>
            (q.state == ST_FILL && q.fill_cnt == '0));

endmodule

// File: rtl/echo_bit_store.sv
module echo_bit_store #(
    parameter int DEPTH  = 8192,
    parameter int WORD_W = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic restart_i,
    input  logic pattern_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int BW    = $clog2(WORD_W);
    localparam int WORDS = DEPTH / WORD_W;
    localparam int WAW   = AW - BW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          dout;
    } store_t;

    store_t q, d;
    logic [WORD_W-1:0] mem_q [WORDS];
    logic [WAW-1:0]    wsel;
    logic [BW-1:0]     bsel;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] wr_word;
    logic              wr_bit;

    always_comb begin
        wsel    = q.addr[AW-1:BW];
        bsel    = q.addr[BW-1:0];
        rd_word = mem_q[wsel];
        wr_bit  = pattern_i ? q.addr[0] : din_i;
        wr_word = rd_word;
        wr_word[bsel] = wr_bit;
        d = q;
        if (tick_i) begin
            d.dout = rd_word[bsel];
            d.addr = q.addr + AW'(1);
        end
        if (restart_i) begin
            d.addr = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '0;
        else       q <= d;
    end

    always_ff @(posedge clk_i) begin
        if (tick_i) mem_q[wsel] <= wr_word;
    end

    assign dout_o = q.dout;

    // R2: the single address wraps modulo the depth
    a_r2_addr_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !restart_i && q.addr == AW'(DEPTH - 1)) |=> (q.addr == '0));

    // R9: without a sample tick or restart the address stays put
    a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !restart_i) |=> $stable(q.addr));

endmodule

// File: rtl/echo_delay_line.sv
module echo_delay_line
    import echo_dl_pkg::*;
#(
    parameter int CLK_DIV = 6,
    parameter int DEPTH   = 8192,
    parameter int WORD_W  = 16
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       sample_i,
    input  logic [1:0] mode_i,
    output logic       echo_o,
    output logic       mute_o,
    output logic       strobe_o
);
    logic tick, run_en, restart, pattern;

    echo_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .run_en_i(run_en),
        .tick_o  (tick),
        .strobe_o(strobe_o)
    );

    echo_mode_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .mode_i   (mode_i),
        .tick_i   (tick),
        .run_en_o (run_en),
        .restart_o(restart),
        .pattern_o(pattern),
        .mute_o   (mute_o)
    );

    echo_bit_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick),
        .restart_i(restart),
        .pattern_i(pattern),
        .din_i    (sample_i),
        .dout_o   (echo_o)
    );

    // R1: strobe is one cycle wide
    a_r1_strobe_one_wide: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o);

    // R2: the echo bit moves only together with a strobe
    a_r2_echo_moves_with_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_o |-> $stable(echo_o));

    // R9: two cycles of halt code leave no strobe
    a_r9_halt_no_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_is_halt($past(mode_i, 2)) && mode_is_halt($past(mode_i))) |-> !strobe_o);

endmodule

// File: tb/echo_delay_line_test.sv
module echo_delay_line_test;
    localparam int DEPTH = 8192;
    localparam int DIV   = 6;
    localparam int NRUN  = DEPTH + 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       echo, mute, strobe;

    int n_vec  = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic hist [NRUN];

    always #5 clk = ~clk;

    echo_delay_line uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .sample_i(sample),
        .mode_i  (mode),
        .echo_o  (echo),
        .mute_o  (mute),
        .strobe_o(strobe)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!strobe);
    endtask

    task automatic count_muted(input string req, output int muted);
        int gap;
        muted = 0;
        forever begin
            wait_strobe(gap);
            if (!mute) break;
            muted++;
        end
        chk(muted == DEPTH - 1, req, muted, DEPTH - 1);
    endtask

    // R5: reset state
    task automatic t_reset();
        rst = 1'b1;
        mode = 2'b00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(mute == 1'b1, "R5 mute in reset", int'(mute), 1);
        chk(strobe == 1'b0, "R5 strobe in reset", int'(strobe), 0);
        chk(echo == 1'b0, "R5 echo in reset", int'(echo), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mute == 1'b1, "R5 mute after reset", int'(mute), 1);
    endtask

    // R1 period, R7 early run request during the first fill
    task automatic t_first_fill();
        int gap, muted;
        muted = 0;
        wait_strobe(gap);
        muted++;
        for (int i = 0; i < 3; i++) begin
            wait_strobe(gap);
            chk(gap == DIV, "R1 strobe period", gap, DIV);
            muted++;
        end
        forever begin
            wait_strobe(gap);
            if (!mute) break;
            muted++;
        end
        chk(muted == DEPTH - 1, "R7 muted strobes before unmute", muted, DEPTH - 1);
    endtask

    // R6 idle pattern, R2 exact delay
    task automatic t_run_delay();
        int gap;
        for (int j = 0; j < NRUN; j++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hist[j] = lfsr[0];
            sample = lfsr[0];
            wait_strobe(gap);
            if (j < DEPTH)
                chk(echo == 1'(j & 1), "R6 idle pattern", int'(echo), j & 1);
            else
                chk(echo == hist[j - DEPTH], "R2 delayed bit", int'(echo), int'(hist[j - DEPTH]));
            if (j == 0 || j == NRUN - 1)
                chk(mute == 1'b0, "R4 unmuted while running", int'(mute), 0);
        end
    endtask

    // R3 alternate mute code, R4 immediate mute, R9 halt freeze, R8 refill
    task automatic t_mute_halt_refill();
        int gap, muted;
        logic held;
        mode = 2'b11;
        @(negedge clk);
        chk(mute == 1'b1, "R4 mute after code 11", int'(mute), 1);
        wait_strobe(gap);
        wait_strobe(gap);
        chk(gap == DIV, "R3 strobes continue in mute", gap, DIV);
        mode = 2'b10;
        @(negedge clk);
        @(negedge clk);
        held = echo;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (strobe !== 1'b0 || echo !== held || mute !== 1'b1) begin
                chk(1'b0, "R9 halt freeze", int'(strobe), 0);
                break;
            end
        end
        chk(echo == held, "R9 echo held in halt", int'(echo), int'(held));
        chk(mute == 1'b1, "R4 mute in halt", int'(mute), 1);
        mode = 2'b00;
        count_muted("R8 full refill after halt", muted);
        for (int j = 0; j < 64; j++) begin
            sample = 1'b1;
            wait_strobe(gap);
            chk(echo == 1'(j & 1), "R6 pattern after refill", int'(echo), j & 1);
        end
    endtask

    initial begin
        t_reset();
        t_first_fill();
        t_run_delay();
        t_mute_halt_refill();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule